// File: doc/BRIEF.md
# Prioritized Bus Arbiter with Software Waits

This block shares one internal bus among three parties: a hold request raised by the flash controller, a DMA controller and a CPU. Only one party owns the bus at a time, and the owner is chosen by fixed priority in a dedicated arbitration cycle. Every access is stretched by zero or one software wait. The number of waits depends on the address region that the access falls in and on three configuration bits. A CPU word access at an odd address is cut into two byte accesses, at the address and at the address plus one. The two halves run back to back as one locked unit, so no other party can take the bus between them.

While the flash controller holds the bus, both masters are stalled. The I/O port outputs are frozen. The watchdog is paused unless count-source protection is on.

The state machine has four states:

- `ST_IDLE` is the arbitration cycle. It moves to `ST_HOLD` on a hold, and to `ST_ACC` when a master wins.
- `ST_ACC` is the first access cycle. With no wait it completes there. It moves to `ST_WAIT` when the region needs a wait.
- `ST_WAIT` is the wait cycle, and it always completes the access.
- `ST_HOLD` is the bus-hold state. It returns to `ST_IDLE` once the hold condition drops.

When an access completes, the machine goes to `ST_IDLE`. The one exception is the first half of a split word, which goes straight back to `ST_ACC` for the second half at the address plus one.

Top module: `bus_arb`

## Requirements
- R1: In the arbitration cycle the winner is chosen by fixed priority: the hold condition first, then `dma_req`, then `cpu_req`.
- R2: `hold_gnt`, `dma_gnt` and `cpu_gnt` are never high together; after each access that ends a request, one cycle with no grant follows, and arbitration takes place in that cycle.
- R3: The hold condition is `fl_ew_mode` and `fl_auto_busy` both high. `fl_ew_mode` alone has no effect. While `hold_gnt` is high, neither master is granted, and `cpu_stall`/`dma_stall` equal their requests.
- R4: `wdt_pause` is high exactly while `hold_gnt` is high and `cs_protect` is 0.
- R5: `port_freeze` is high exactly while `hold_gnt` is high.
- R6: A CPU word access (`cpu_word`=1) at an odd address is done as two byte accesses, first at `cpu_addr` and then at `cpu_addr`+1. The second cycle follows the first with no arbitration cycle between them, and `dma_req` raised during the first half waits until the pair is over.
- R7: A master's stall is its request and not its final completion. An access without wait takes one cycle with `acc_done` high. An access with a wait takes two cycles, with `acc_done` high only in the second. `bus_addr` shows the access address while granted and 0 otherwise.
- R8: The regions are `addr<0x0400` peripheral registers, `<0x4000` RAM, `<0x8000` data flash, `<0xC000` program ROM 2, and the rest program ROM 1. The peripheral-register region waits when `wait_cfg[0]`=1. RAM and both ROMs wait when `wait_cfg[1]`=1. Data flash waits when `wait_cfg[1]` or `wait_cfg[2]` is 1.
- R9: A hold only takes the bus at an access boundary. A hold raised during the first half of a locked pair waits for both halves, and it is granted one cycle after the arbitration cycle that follows the pair.
- R10: During reset there are no grants, no stalls beyond the requests, and `acc_done`, `wdt_pause`, `port_freeze` and `bus_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fl_ew_mode | input | 1 | Flash is in erase-write mode 1 |
| fl_auto_busy | input | 1 | Flash automatic program or erase is running |
| cs_protect | input | 1 | Count-source protection enabled |
| wait_cfg | input | 3 | Software wait select bits |
| dma_req | input | 1 | DMA request, held until final completion |
| dma_addr | input | AW | DMA access address |
| cpu_req | input | 1 | CPU request, held until final completion |
| cpu_addr | input | AW | CPU access address |
| cpu_word | input | 1 | CPU access is a word |
| hold_gnt | output | 1 | Bus held by flash controller |
| dma_gnt | output | 1 | DMA owns the bus |
| cpu_gnt | output | 1 | CPU owns the bus |
| dma_stall | output | 1 | DMA must keep waiting |
| cpu_stall | output | 1 | CPU must keep waiting |
| wdt_pause | output | 1 | Watchdog count paused |
| port_freeze | output | 1 | I/O port outputs held |
| acc_done | output | 1 | Current access completes this cycle |
| bus_addr | output | AW | Address of the current access |

## Verification
A request applied between clock edges is arbitrated at the next edge. Its grant is visible one cycle later, and `acc_done` follows one cycle after that if the region waits. The second half of a split word appears one cycle after the first half completes. After any final completion there is exactly one cycle with no grant before the next owner shows. A hold appears one cycle after its arbitration cycle, and it is released one cycle after the condition drops. The bench drives all inputs and samples all outputs on the falling edge. It counts falling edges from the stimulus and compares grants, stalls, `acc_done` and `bus_addr` at precisely the cycle these latencies predict.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [2:0] {
        REG_PERIPH,
        REG_RAM,
        REG_DFLASH,
        REG_ROM2,
        REG_ROM1
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC,
        ST_WAIT,
        ST_HOLD
    } arb_state_e;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_DMA,
        OWN_CPU
    } owner_e;

endpackage

// File: rtl/bus_arb_region_dec.sv
module bus_arb_region_dec
    import bus_arb_pkg::*;
#(
    parameter int AW        = 16,
    parameter int PERIPH_TOP = 'h0400,
    parameter int RAM_TOP   = 'h4000,
    parameter int DF_TOP    = 'h8000,
    parameter int ROM2_TOP  = 'hC000
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    localparam logic [AW-1:0] PERIPH_L = AW'(PERIPH_TOP);
    localparam logic [AW-1:0] RAM_L    = AW'(RAM_TOP);
    localparam logic [AW-1:0] DF_L     = AW'(DF_TOP);
    localparam logic [AW-1:0] ROM2_L   = AW'(ROM2_TOP);

    always_comb begin
        if (addr < PERIPH_L)      region = REG_PERIPH;
        else if (addr < RAM_L)    region = REG_RAM;
        else if (addr < DF_L)     region = REG_DFLASH;
        else if (addr < ROM2_L)   region = REG_ROM2;
        else                      region = REG_ROM1;
    end
endmodule

// File: rtl/bus_arb_wait_sel.sv
module bus_arb_wait_sel
    import bus_arb_pkg::*;
#(
    parameter int CFG_W = 3
) (
    input  region_e          region,
    input  logic [CFG_W-1:0] cfg,
    output logic             need_wait
);
    always_comb begin
        unique case (region)
            REG_PERIPH: need_wait = cfg[0];
            REG_DFLASH: need_wait = cfg[1] | cfg[2];
            default:    need_wait = cfg[1];
        endcase
    end
endmodule

// File: rtl/bus_arb_prio.sv
module bus_arb_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    for (genvar i = 0; i < N; i++) begin : g_lvl
        if (i == 0) begin : g_top
            assign pick[i] = req[i];
        end else begin : g_low
            assign pick[i] = req[i] & ~(|req[i-1:0]);
        end
    end
endmodule

// File: rtl/bus_arb.sv
module bus_arb
    import bus_arb_pkg::*;
#(
    parameter int AW         = 16,
    parameter int CFG_W      = 3,
    parameter int PERIPH_TOP = 'h0400,
    parameter int RAM_TOP    = 'h4000,
    parameter int DF_TOP     = 'h8000,
    parameter int ROM2_TOP   = 'hC000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fl_ew_mode,
    input  logic             fl_auto_busy,
    input  logic             cs_protect,
    input  logic [CFG_W-1:0] wait_cfg,
    input  logic             dma_req,
    input  logic [AW-1:0]    dma_addr,
    input  logic             cpu_req,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_word,
    output logic             hold_gnt,
    output logic             dma_gnt,
    output logic             cpu_gnt,
    output logic             dma_stall,
    output logic             cpu_stall,
    output logic             wdt_pause,
    output logic             port_freeze,
    output logic             acc_done,
    output logic [AW-1:0]    bus_addr
);
    localparam int NREQ = 3;

    arb_state_e    state_q, state_d;
    owner_e        owner_q, owner_d;
    logic [AW-1:0] addr_q, addr_d;
    logic          split_q, split_d;
    logic          second_q, second_d;

    logic            hold_cond;
    logic [NREQ-1:0] pick;
    region_e         region;
    logic            need_wait;
    logic            in_acc;
    logic            last_half;

    assign hold_cond = fl_ew_mode & fl_auto_busy;

    bus_arb_prio #(.N(NREQ)) u_prio (
        .req  ({cpu_req, dma_req, hold_cond}),
        .pick (pick)
    );

    bus_arb_region_dec #(
        .AW(AW), .PERIPH_TOP(PERIPH_TOP), .RAM_TOP(RAM_TOP),
        .DF_TOP(DF_TOP), .ROM2_TOP(ROM2_TOP)
    ) u_dec (
        .addr   (addr_q),
        .region (region)
    );

    bus_arb_wait_sel #(.CFG_W(CFG_W)) u_wait (
        .region    (region),
        .cfg       (wait_cfg),
        .need_wait (need_wait)
    );

    // next-state and datapath decisions
    always_comb begin
        state_d  = state_q;
        owner_d  = owner_q;
        addr_d   = addr_q;
        split_d  = split_q;
        second_d = second_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick[0]) begin
                    state_d = ST_HOLD;
                end else if (pick[1]) begin
                    state_d = ST_ACC;
                    owner_d = OWN_DMA;
                    addr_d  = dma_addr;
                    split_d = 1'b0;
                end else if (pick[2]) begin
                    state_d = ST_ACC;
                    owner_d = OWN_CPU;
                    addr_d  = cpu_addr;
                    split_d = cpu_word & cpu_addr[0];
                end
            end
            ST_ACC, ST_WAIT: begin
                if (state_q == ST_ACC && need_wait) begin
                    state_d = ST_WAIT;
                end else if (split_q && !second_q) begin
                    state_d  = ST_ACC;
                    second_d = 1'b1;
                    addr_d   = addr_q + AW'(1);
                end else begin
                    state_d  = ST_IDLE;
                    owner_d  = OWN_NONE;
                    split_d  = 1'b0;
                    second_d = 1'b0;
                end
            end
            ST_HOLD: begin
                if (!hold_cond) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            owner_q  <= OWN_NONE;
            addr_q   <= '0;
            split_q  <= 1'b0;
            second_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            addr_q   <= addr_d;
            split_q  <= split_d;
            second_q <= second_d;
        end
    end

    // outputs
    always_comb begin
        in_acc      = (state_q == ST_ACC) || (state_q == ST_WAIT);
        last_half   = !split_q || second_q;
        acc_done    = (state_q == ST_WAIT) || (state_q == ST_ACC && !need_wait);
        cpu_gnt     = in_acc && owner_q == OWN_CPU;
        dma_gnt     = in_acc && owner_q == OWN_DMA;
        hold_gnt    = state_q == ST_HOLD;
        cpu_stall   = cpu_req && !(cpu_gnt && acc_done && last_half);
        dma_stall   = dma_req && !(dma_gnt && acc_done);
        wdt_pause   = hold_gnt && !cs_protect;
        port_freeze = hold_gnt;
        bus_addr    = in_acc ? addr_q : '0;
    end
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fl_ew_mode,
    input logic          fl_auto_busy,
    input logic          cs_protect,
    input logic          dma_req,
    input logic          cpu_req,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_word,
    input logic          hold_gnt,
    input logic          dma_gnt,
    input logic          cpu_gnt,
    input logic          dma_stall,
    input logic          cpu_stall,
    input logic          wdt_pause,
    input logic          port_freeze,
    input logic          acc_done,
    input logic [AW-1:0] bus_addr
);
    p_dma_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_gnt) |-> $past(!(fl_ew_mode && fl_auto_busy)));

    p_cpu_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_gnt) |-> $past(!dma_req && !(fl_ew_mode && fl_auto_busy)));

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold_gnt, dma_gnt, cpu_gnt}));

    p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_gnt |-> (cpu_stall == cpu_req) && (dma_stall == dma_req));

    p_wdt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_pause |-> hold_gnt && !cs_protect);

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_gnt |-> port_freeze);

    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && acc_done && cpu_word && cpu_addr[0] && bus_addr == cpu_addr)
        |=> cpu_gnt && bus_addr == $past(cpu_addr) + AW'(1));

    p_one_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_gnt || dma_gnt) && !acc_done) |=> acc_done);

    p_done_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (cpu_gnt || dma_gnt));

    p_hold_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_gnt) |-> $past(!cpu_gnt && !dma_gnt));
endmodule

bind bus_arb bus_arb_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fl_ew_mode(fl_ew_mode), .fl_auto_busy(fl_auto_busy),
    .cs_protect(cs_protect), .dma_req(dma_req), .cpu_req(cpu_req),
    .cpu_addr(cpu_addr), .cpu_word(cpu_word), .hold_gnt(hold_gnt),
    .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt), .dma_stall(dma_stall),
    .cpu_stall(cpu_stall), .wdt_pause(wdt_pause), .port_freeze(port_freeze),
    .acc_done(acc_done), .bus_addr(bus_addr)
);

// File: tb/bus_arb_test.sv
module bus_arb_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fl_ew_mode = 1'b0, fl_auto_busy = 1'b0, cs_protect = 1'b0;
    logic [2:0]    wait_cfg = 3'b111;
    logic          dma_req = 1'b0, cpu_req = 1'b0, cpu_word = 1'b0;
    logic [AW-1:0] dma_addr = '0, cpu_addr = '0;
    logic          hold_gnt, dma_gnt, cpu_gnt, dma_stall, cpu_stall;
    logic          wdt_pause, port_freeze, acc_done;
    logic [AW-1:0] bus_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    bus_arb uut (
        .clk(clk), .rst_n(rst_n), .fl_ew_mode(fl_ew_mode), .fl_auto_busy(fl_auto_busy),
        .cs_protect(cs_protect), .wait_cfg(wait_cfg), .dma_req(dma_req),
        .dma_addr(dma_addr), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_word(cpu_word), .hold_gnt(hold_gnt), .dma_gnt(dma_gnt),
        .cpu_gnt(cpu_gnt), .dma_stall(dma_stall), .cpu_stall(cpu_stall),
        .wdt_pause(wdt_pause), .port_freeze(port_freeze), .acc_done(acc_done),
        .bus_addr(bus_addr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below 50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R8 wait model
    function automatic int wt(input logic [AW-1:0] a, input logic [2:0] c);
        if (a < 16'h0400)      return int'(c[0]);
        else if (a < 16'h4000) return int'(c[1]);
        else if (a < 16'h8000) return int'(c[1] | c[2]);
        else                   return int'(c[1]);
    endfunction

    task automatic cpu_access(input logic [AW-1:0] a, input logic w, input logic [2:0] c,
                              input string tag);
        int n = 0;
        int expn;
        logic split;
        split = w & a[0];
        expn = 1 + wt(a, c);
        if (split) expn = expn + 1 + wt(a + 16'd1, c);
        @(negedge clk);
        wait_cfg = c; cpu_addr = a; cpu_word = w; cpu_req = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            n++;
            if (cpu_gnt && acc_done && !cpu_stall) break;
        end
        chk({tag, " cycles"}, n, expn);
        chk({tag, " addr"}, bus_addr, split ? a + 16'd1 : a);
        cpu_req = 1'b0; cpu_word = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10 grants", {hold_gnt, dma_gnt, cpu_gnt}, 0);
        chk("R10 done/wdt/freeze", {acc_done, wdt_pause, port_freeze}, 0);
        chk("R10 addr", bus_addr, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_waits;
        cpu_access(16'h0800, 1'b0, 3'b000, "R7 ram nowait");
        cpu_access(16'h0800, 1'b0, 3'b111, "R7 ram wait");
        cpu_access(16'h0010, 1'b0, 3'b001, "R8 periph cfg0");
        cpu_access(16'h0800, 1'b0, 3'b001, "R8 ram cfg0");
        cpu_access(16'h5000, 1'b0, 3'b100, "R8 dflash cfg2");
        cpu_access(16'hD000, 1'b0, 3'b100, "R8 rom1 cfg2");
        cpu_access(16'h9000, 1'b0, 3'b010, "R8 rom2 cfg1");
        cpu_access(16'h0010, 1'b0, 3'b010, "R8 periph cfg1");
        cpu_access(16'h5000, 1'b0, 3'b010, "R8 dflash cfg1");
        cpu_access(16'h0802, 1'b1, 3'b000, "R6 even word");
        cpu_access(16'h0801, 1'b1, 3'b111, "R6 odd word wait");
    endtask

    task automatic t_pair_vs_dma;
        @(negedge clk);
        wait_cfg = 3'b000; cpu_addr = 16'h0501; cpu_word = 1'b1; cpu_req = 1'b1;
        @(negedge clk);
        chk("R6 first half", {cpu_gnt, acc_done, cpu_stall}, 3'b111);
        chk("R6 first addr", bus_addr, 16'h0501);
        dma_addr = 16'h0600; dma_req = 1'b1;
        @(negedge clk);
        chk("R6 second half", {cpu_gnt, dma_gnt, cpu_stall, dma_stall}, 4'b1001);
        chk("R6 second addr", bus_addr, 16'h0502);
        cpu_req = 1'b0; cpu_word = 1'b0;
        @(negedge clk);
        chk("R2 gap after pair", {hold_gnt, dma_gnt, cpu_gnt}, 0);
        @(negedge clk);
        chk("R6 dma after pair", {dma_gnt, acc_done, dma_stall}, 3'b110);
        dma_req = 1'b0;
    endtask

    task automatic t_priority;
        @(negedge clk);
        wait_cfg = 3'b000;
        cpu_addr = 16'h0400; cpu_req = 1'b1;
        dma_addr = 16'h0402; dma_req = 1'b1;
        @(negedge clk);
        chk("R1 dma over cpu", {dma_gnt, cpu_gnt, cpu_stall}, 3'b101);
        chk("R7 dma addr", bus_addr, 16'h0402);
        dma_req = 1'b0;
        @(negedge clk);
        chk("R2 arbitration gap", {hold_gnt, dma_gnt, cpu_gnt}, 0);
        chk("R7 idle addr", bus_addr, 0);
        @(negedge clk);
        chk("R1 cpu served", {cpu_gnt, acc_done, cpu_stall}, 3'b110);
        cpu_req = 1'b0;
    endtask

    task automatic t_hold(input logic cs);
        @(negedge clk);
        wait_cfg = 3'b000; cs_protect = cs;
        fl_ew_mode = 1'b1; fl_auto_busy = 1'b1;
        cpu_addr = 16'h0800; cpu_req = 1'b1;
        dma_addr = 16'h0900; dma_req = 1'b1;
        @(negedge clk);
        chk("R1 hold wins", {hold_gnt, dma_gnt, cpu_gnt}, 3'b100);
        chk("R3 stalls", {cpu_stall, dma_stall}, 2'b11);
        chk("R4 wdt pause", wdt_pause, !cs);
        chk("R5 freeze", port_freeze, 1'b1);
        fl_auto_busy = 1'b0; dma_req = 1'b0;
        @(negedge clk);
        chk("R5 release", {hold_gnt, port_freeze, wdt_pause}, 0);
        @(negedge clk);
        chk("R3 cpu after hold", {cpu_gnt, acc_done}, 2'b11);
        cpu_req = 1'b0; fl_ew_mode = 1'b0; cs_protect = 1'b0;
    endtask

    task automatic t_hold_after_pair;
        @(negedge clk);
        wait_cfg = 3'b111; cpu_addr = 16'h0501; cpu_word = 1'b1; cpu_req = 1'b1;
        @(negedge clk);
        fl_ew_mode = 1'b1; fl_auto_busy = 1'b1;
        @(negedge clk);
        chk("R9 first half done", {cpu_gnt, acc_done, hold_gnt}, 3'b110);
        @(negedge clk);
        chk("R9 hold waits pair", {cpu_gnt, hold_gnt}, 2'b10);
        @(negedge clk);
        chk("R9 pair final", {cpu_gnt, acc_done, cpu_stall}, 3'b110);
        cpu_req = 1'b0; cpu_word = 1'b0;
        @(negedge clk);
        chk("R9 arbitration", hold_gnt, 1'b0);
        @(negedge clk);
        chk("R9 hold granted", {hold_gnt, wdt_pause}, 2'b11);
        fl_auto_busy = 1'b0;
        @(negedge clk);
        fl_ew_mode = 1'b0;
    endtask

    task automatic t_ew_only;
        @(negedge clk);
        wait_cfg = 3'b000; fl_ew_mode = 1'b1; fl_auto_busy = 1'b0;
        cpu_addr = 16'h0800; cpu_req = 1'b1;
        @(negedge clk);
        chk("R3 ew alone ignored", {hold_gnt, cpu_gnt, acc_done, port_freeze}, 4'b0110);
        cpu_req = 1'b0;
        @(negedge clk);
        fl_ew_mode = 1'b0;
    endtask

    task automatic t_dma_wait;
        @(negedge clk);
        wait_cfg = 3'b100; dma_addr = 16'h5000; dma_req = 1'b1;
        @(negedge clk);
        chk("R7 dma wait cycle", {dma_gnt, acc_done, dma_stall}, 3'b101);
        @(negedge clk);
        chk("R7 dma done", {dma_gnt, acc_done, dma_stall}, 3'b110);
        dma_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_waits();
        t_pair_vs_dma();
        t_priority();
        t_hold(1'b0);
        t_hold(1'b1);
        t_hold_after_pair();
        t_ew_only();
        t_dma_wait();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule